// File: doc/BRIEF.md
# Asymmetric Dual-Issue Pairing Unit

The pairing unit sits between a fetch buffer and two execution pipes. Each cycle it looks at the two oldest decoded instructions in the buffer. It sorts each one into an integer-side class or a floating-point computation class. It then decides whether both can leave together, or only the older one, or neither. It raises valid/ready handshakes towards an integer issue port and a floating-point issue port. It also returns a count that tells the fetch buffer how many of its two head entries were taken.

The two issue slots are not alike. Each cycle, at most one instruction goes to the integer pipe and at most one goes to the floating-point computation pipe. Floating-point loads and stores count as integer-side work, because they use the memory path. Dispatch is strictly in order. A read-after-write dependency between the pair, an unknown operation group, or backpressure on the older instruction's port each stops the younger instruction from going out in the same cycle. The unit holds no state. Its clock and reset serve only the cycle checks.

Top module: `pair_issue_unit`

## Requirements
- R1: The operation group codes 0 (ALU), 1 (branch), 2 (load), 3 (store), 4 (FP load) and 5 (FP store) are integer-side. A lone valid slot-0 instruction with one of these codes raises int_valid with int_sel=0, leaves fp_valid low, and gives consumed=1 when int_ready is high.
- R2: The group codes 8 (FP add), 9 (FP subtract), 10 (FP multiply-add), 11 (FP convert) and 12 (FP multiply) are floating-point computation. A lone slot-0 instruction with one of these codes raises fp_valid with fp_sel=0, leaves int_valid low, and gives consumed=1.
- R3: When both slots are valid and hold one integer-side and one FP-computation instruction, with no dependency and both ports ready, both ports are valid and consumed=2. This holds in either age order.
- R4: Two integer-side instructions, or two FP-computation instructions, never issue together. Only slot 0 goes out and consumed=1.
- R5: If slot 0 writes a register (destination enable set) and the 6-bit index of that register equals any enabled source index of slot 1, only slot 0 issues. A matching index on a disabled source, or a destination with its enable clear, does not block the pair.
- R6: The group codes 6, 7, 13, 14 and 15 are unknown. An unknown instruction is steered to the integer port and never pairs, whether it is the older or the younger slot.
- R7: When the port of slot 0 has ready low, the younger instruction's port shows no valid for it, and consumed=0.
- R8: When slot 0's port is ready but the paired younger instruction's port is not, the younger stays valid and consumed=1.
- R9: With slot 0 not valid, neither port is valid and consumed=0, whatever slot 1 holds. This includes the idle state during reset.
- R10: int_sel and fp_sel name the fetch-buffer slot (0 = older, 1 = younger) whose instruction is on that port. Two valid ports never name the same slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used by the cycle checks) |
| rst_n | input | 1 | Asynchronous active-low reset |
| s0_valid | input | 1 | Older slot holds an instruction |
| s0_grp | input | GRP_W | Older slot operation group code |
| s0_dst_en | input | 1 | Older slot writes a register |
| s0_dst | input | REG_W | Older slot destination index (bit 5 selects the FP file) |
| s0_src_en | input | NSRC | Older slot source enables |
| s0_src | input | NSRC*REG_W | Older slot source indices, source k at bits k*REG_W upward |
| s1_valid | input | 1 | Younger slot holds an instruction |
| s1_grp | input | GRP_W | Younger slot operation group code |
| s1_dst_en | input | 1 | Younger slot writes a register |
| s1_dst | input | REG_W | Younger slot destination index |
| s1_src_en | input | NSRC | Younger slot source enables |
| s1_src | input | NSRC*REG_W | Younger slot source indices |
| int_valid | output | 1 | Instruction offered to the integer pipe |
| int_sel | output | 1 | Slot feeding the integer pipe |
| int_ready | input | 1 | Integer pipe accepts |
| fp_valid | output | 1 | Instruction offered to the FP computation pipe |
| fp_sel | output | 1 | Slot feeding the FP pipe |
| fp_ready | input | 1 | FP pipe accepts |
| consumed | output | 2 | Fetch-buffer entries taken this cycle (0, 1 or 2) |

## Verification
On every cycle, the assertions check the structural limits. These are: two valid ports never name the same slot, a same-class pair or an unknown group never produces two valid ports, a detected dependency suppresses pairing, the younger instruction never fires unless the older one does, and an empty slot 0 keeps everything idle. The assertions cannot tell whether a given group code landed in the right class, or whether the dependency compare picks up exactly the enabled sources. Only the bench's directed scenarios can show those, along with the exact consumed value under each pattern of ready.

// File: rtl/pair_pkg.sv
package pair_pkg;
  typedef enum logic [1:0] {
    CL_INT = 2'd0,
    CL_FP  = 2'd1,
    CL_UNK = 2'd2
  } iclass_e;
endpackage

// File: rtl/pair_classify.sv
module pair_classify
  import pair_pkg::*;
#(
  parameter int GRP_W = 4
) (
  input  logic [GRP_W-1:0] grp,
  output iclass_e          cls
);
  always_comb begin
    case (grp)
      GRP_W'(0), GRP_W'(1), GRP_W'(2),
      GRP_W'(3), GRP_W'(4), GRP_W'(5):   cls = CL_INT;
      GRP_W'(8), GRP_W'(9), GRP_W'(10),
      GRP_W'(11), GRP_W'(12):            cls = CL_FP;
      default:                           cls = CL_UNK;
    endcase
  end
endmodule

// File: rtl/pair_hazard.sv
module pair_hazard #(
  parameter int REG_W = 6,
  parameter int NSRC  = 3
) (
  input  logic                  wr_en,
  input  logic [REG_W-1:0]      wr_idx,
  input  logic [NSRC-1:0]       rd_en,
  input  logic [NSRC*REG_W-1:0] rd_idx,
  output logic                  raw
);
  logic [NSRC-1:0] hit;

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    assign hit[k] = rd_en[k] && (rd_idx[k*REG_W +: REG_W] == wr_idx);
  end

  assign raw = wr_en && (|hit);
endmodule

// File: rtl/pair_steer.sv
module pair_steer
  import pair_pkg::*;
(
  input  logic    v0,
  input  logic    v1,
  input  iclass_e cls0,
  input  iclass_e cls1,
  input  logic    raw,
  input  logic    int_ready,
  input  logic    fp_ready,
  output logic    int_valid,
  output logic    int_sel,
  output logic    fp_valid,
  output logic    fp_sel,
  output logic [1:0] consumed
);
  logic old_fp, yng_fp, pair_ok, old_rdy, yng_rdy, yng_v, fire0, fire1;

  always_comb begin
    old_fp  = (cls0 == CL_FP);
    yng_fp  = (cls1 == CL_FP);
    pair_ok = v0 && v1 && (cls0 != CL_UNK) && (cls1 != CL_UNK)
              && (old_fp != yng_fp) && !raw;
    old_rdy = old_fp ? fp_ready : int_ready;
    yng_rdy = yng_fp ? fp_ready : int_ready;
    yng_v   = pair_ok && old_rdy;

    int_valid = (v0 && !old_fp) || (yng_v && !yng_fp);
    int_sel   = old_fp;
    fp_valid  = (v0 && old_fp) || (yng_v && yng_fp);
    fp_sel    = !old_fp;

    fire0 = v0 && old_rdy;
    fire1 = yng_v && yng_rdy;
    if (fire1)      consumed = 2'd2;
    else if (fire0) consumed = 2'd1;
    else            consumed = 2'd0;
  end
endmodule

// File: rtl/pair_issue_unit.sv
module pair_issue_unit
  import pair_pkg::*;
#(
  parameter int GRP_W = 4,
  parameter int REG_W = 6,
  parameter int NSRC  = 3,
  localparam int SRC_W = NSRC * REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s0_valid,
  input  logic [GRP_W-1:0] s0_grp,
  input  logic             s0_dst_en,
  input  logic [REG_W-1:0] s0_dst,
  input  logic [NSRC-1:0]  s0_src_en,
  input  logic [SRC_W-1:0] s0_src,
  input  logic             s1_valid,
  input  logic [GRP_W-1:0] s1_grp,
  input  logic             s1_dst_en,
  input  logic [REG_W-1:0] s1_dst,
  input  logic [NSRC-1:0]  s1_src_en,
  input  logic [SRC_W-1:0] s1_src,
  output logic             int_valid,
  output logic             int_sel,
  input  logic             int_ready,
  output logic             fp_valid,
  output logic             fp_sel,
  input  logic             fp_ready,
  output logic [1:0]       consumed
);
  iclass_e cls [2];
  logic    raw;
  logic [GRP_W-1:0] grp_v [2];

  assign grp_v[0] = s0_grp;
  assign grp_v[1] = s1_grp;

  for (genvar s = 0; s < 2; s++) begin : g_cls
    pair_classify #(.GRP_W(GRP_W)) u_cls (
      .grp (grp_v[s]),
      .cls (cls[s])
    );
  end

  pair_hazard #(.REG_W(REG_W), .NSRC(NSRC)) u_haz (
    .wr_en  (s0_dst_en),
    .wr_idx (s0_dst),
    .rd_en  (s1_src_en),
    .rd_idx (s1_src),
    .raw    (raw)
  );

  pair_steer u_steer (
    .v0        (s0_valid),
    .v1        (s1_valid),
    .cls0      (cls[0]),
    .cls1      (cls[1]),
    .raw       (raw),
    .int_ready (int_ready),
    .fp_ready  (fp_ready),
    .int_valid (int_valid),
    .int_sel   (int_sel),
    .fp_valid  (fp_valid),
    .fp_sel    (fp_sel),
    .consumed  (consumed)
  );

  // The destination of the younger slot does not affect pairing.
  logic unused_s1;
  assign unused_s1 = s1_dst_en ^ (^s1_dst) ^ (^s0_src_en) ^ (^s0_src);

  // R10: two valid ports never carry the same slot
  a_r10_distinct_slots: assert property (@(posedge clk) disable iff (!rst_n)
    (int_valid && fp_valid) |-> (int_sel != fp_sel));

  // R4: a same-class pair never offers both ports
  a_r4_same_class_solo: assert property (@(posedge clk) disable iff (!rst_n)
    (s0_valid && s1_valid && cls[0] == cls[1]) |-> !(int_valid && fp_valid));

  // R5: a detected dependency stops the younger slot
  a_r5_raw_solo: assert property (@(posedge clk) disable iff (!rst_n)
    raw |-> (consumed != 2'd2) && !(int_valid && fp_valid));

  // R6: an unknown group never pairs
  a_r6_unknown_solo: assert property (@(posedge clk) disable iff (!rst_n)
    (cls[0] == CL_UNK || (s1_valid && cls[1] == CL_UNK)) |-> consumed != 2'd2);

  // R7: the younger fires only with the older
  a_r7_int_in_order: assert property (@(posedge clk) disable iff (!rst_n)
    (int_valid && int_ready && int_sel) |-> (fp_valid && fp_ready && !fp_sel));
  a_r7_fp_in_order: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_valid && fp_ready && fp_sel) |-> (int_valid && int_ready && !int_sel));

  // R8: count stays within the two head slots
  a_r8_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    consumed != 2'd3);

  // R9: an empty head slot keeps both ports idle
  a_r9_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !s0_valid |-> (!int_valid && !fp_valid && consumed == 2'd0));
endmodule

// File: tb/sim_pair_issue_unit.sv
module sim_pair_issue_unit;
  logic clk = 1'b0;
  logic rst_n;
  logic s0_valid, s1_valid, s0_dst_en, s1_dst_en;
  logic [3:0] s0_grp, s1_grp;
  logic [5:0] s0_dst, s1_dst;
  logic [2:0] s0_src_en, s1_src_en;
  logic [17:0] s0_src, s1_src;
  logic int_valid, int_sel, int_ready, fp_valid, fp_sel, fp_ready;
  logic [1:0] consumed;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pair_issue_unit u0 (.*);

  task automatic ld0(input logic v, input logic [3:0] g, input logic de,
                     input logic [5:0] d, input logic [2:0] se, input logic [17:0] s);
    s0_valid = v; s0_grp = g; s0_dst_en = de; s0_dst = d; s0_src_en = se; s0_src = s;
  endtask

  task automatic ld1(input logic v, input logic [3:0] g, input logic de,
                     input logic [5:0] d, input logic [2:0] se, input logic [17:0] s);
    s1_valid = v; s1_grp = g; s1_dst_en = de; s1_dst = d; s1_src_en = se; s1_src = s;
  endtask

  task automatic chk(input string tag, input logic eiv, input logic eis,
                     input logic efv, input logic efs, input logic [1:0] ec);
    #2;
    n_chk++;
    if (int_valid !== eiv || fp_valid !== efv || consumed !== ec ||
        (eiv && int_sel !== eis) || (efv && fp_sel !== efs)) begin
      n_bad++;
      $display("FAIL %s: got iv=%b is=%b fv=%b fs=%b c=%0d, want iv=%b is=%b fv=%b fs=%b c=%0d",
               tag, int_valid, int_sel, fp_valid, fp_sel, consumed,
               eiv, eis, efv, efs, ec);
    end
  endtask

  task automatic go(input logic ir, input logic fr);
    @(negedge clk);
    int_ready = ir; fp_ready = fr;
  endtask

  task automatic t_reset;
    chk("R9 reset idle", 0, 0, 0, 0, 2'd0);
  endtask

  task automatic t_classes;
    for (int g = 0; g < 6; g++) begin
      go(1, 1); ld0(1, 4'(g), 1, 6'd2, 3'b001, 18'd1); ld1(0, 0, 0, 0, 0, 0);
      chk("R1 int class", 1, 0, 0, 0, 2'd1);
    end
    for (int g = 8; g < 13; g++) begin
      go(1, 1); ld0(1, 4'(g), 1, 6'd33, 3'b011, 18'd34); ld1(0, 0, 0, 0, 0, 0);
      chk("R2 fp class", 0, 0, 1, 0, 2'd1);
    end
  endtask

  task automatic t_pair;
    go(1, 1); ld0(1, 4'd0, 1, 6'd3, 3'b011, 18'd1);
    ld1(1, 4'd8, 1, 6'd35, 3'b011, {6'd0, 6'd34, 6'd33});
    chk("R3 R10 int then fp", 1, 0, 1, 1, 2'd2);
    go(1, 1); ld0(1, 4'd10, 1, 6'd40, 3'b111, {6'd41, 6'd42, 6'd43});
    ld1(1, 4'd2, 1, 6'd5, 3'b001, 18'd1);
    chk("R3 R10 fp then int", 1, 1, 1, 0, 2'd2);
    go(1, 1); ld0(1, 4'd4, 1, 6'd40, 3'b001, 18'd1);
    ld1(1, 4'd8, 1, 6'd44, 3'b011, {6'd0, 6'd41, 6'd42});
    chk("R3 fp load with fp add", 1, 0, 1, 1, 2'd2);
  endtask

  task automatic t_same;
    go(1, 1); ld0(1, 4'd0, 1, 6'd3, 3'b001, 18'd1); ld1(1, 4'd1, 0, 0, 3'b001, 18'd2);
    chk("R4 int+int", 1, 0, 0, 0, 2'd1);
    go(1, 1); ld0(1, 4'd9, 1, 6'd33, 3'b001, 18'd34); ld1(1, 4'd11, 1, 6'd36, 3'b001, 18'd37);
    chk("R4 fp+fp", 0, 0, 1, 0, 2'd1);
  endtask

  task automatic t_raw;
    go(1, 1); ld0(1, 4'd4, 1, 6'd40, 3'b001, 18'd1);
    ld1(1, 4'd12, 1, 6'd44, 3'b111, {6'd40, 6'd41, 6'd42});
    chk("R5 raw on third source", 1, 0, 0, 0, 2'd1);
    go(1, 1); ld1(1, 4'd12, 1, 6'd44, 3'b011, {6'd40, 6'd41, 6'd42});
    chk("R5 disabled source ignored", 1, 0, 1, 1, 2'd2);
    go(1, 1); ld0(1, 4'd5, 0, 6'd40, 3'b001, 18'd1);
    ld1(1, 4'd12, 1, 6'd44, 3'b111, {6'd40, 6'd41, 6'd42});
    chk("R5 no write, no hazard", 1, 0, 1, 1, 2'd2);
  endtask

  task automatic t_unknown;
    go(1, 1); ld0(1, 4'd7, 0, 0, 0, 0); ld1(1, 4'd8, 1, 6'd33, 3'b001, 18'd34);
    chk("R6 unknown older", 1, 0, 0, 0, 2'd1);
    go(1, 1); ld0(1, 4'd9, 1, 6'd33, 0, 0); ld1(1, 4'd13, 0, 0, 0, 0);
    chk("R6 unknown younger after fp", 0, 0, 1, 0, 2'd1);
    go(1, 1); ld0(1, 4'd15, 0, 0, 0, 0); ld1(0, 0, 0, 0, 0, 0);
    chk("R6 unknown alone to int", 1, 0, 0, 0, 2'd1);
  endtask

  task automatic t_back;
    go(0, 1); ld0(1, 4'd0, 1, 6'd3, 3'b001, 18'd1);
    ld1(1, 4'd8, 1, 6'd35, 3'b001, 18'd33);
    chk("R7 older int stalled", 1, 0, 0, 0, 2'd0);
    go(1, 0); ld0(1, 4'd8, 1, 6'd35, 3'b001, 18'd33);
    ld1(1, 4'd0, 1, 6'd3, 3'b001, 18'd1);
    chk("R7 older fp stalled", 0, 0, 1, 0, 2'd0);
    go(1, 0); ld0(1, 4'd0, 1, 6'd3, 3'b001, 18'd1);
    ld1(1, 4'd8, 1, 6'd35, 3'b001, 18'd33);
    chk("R8 younger fp stalled", 1, 0, 1, 1, 2'd1);
  endtask

  task automatic t_empty;
    go(1, 1); ld0(0, 4'd0, 0, 0, 0, 0); ld1(1, 4'd0, 1, 6'd3, 3'b001, 18'd1);
    chk("R9 slot0 empty", 0, 0, 0, 0, 2'd0);
  endtask

  initial begin
    rst_n = 1'b0; int_ready = 1'b1; fp_ready = 1'b1;
    ld0(0, 0, 0, 0, 0, 0); ld1(0, 0, 0, 0, 0, 0);
    @(negedge clk);
    t_reset;
    @(negedge clk); rst_n = 1'b1;
    t_classes; t_pair; t_same; t_raw; t_unknown; t_back; t_empty;
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout, want completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule